// File: doc/BRIEF.md
# Directory-Protocol Cache Line Controller

This block is the cache side of a directory-based coherence scheme. It holds a direct-mapped set of lines, each one word wide. Each line keeps a tag and one of three states: not present, readable copy, or writable owned copy. The processor issues loads and stores to the block. Hits complete locally. Misses become request messages to the home directory, and the processor is held off until the directory's data reply comes back. Incoming directory commands can revoke a readable copy, demote an owned copy to readable, or take an owned copy away entirely. The last two return the line's data to the home in a write-back message.

A miss can land on a slot that an owned line of another block occupies. In that case the controller first returns the old block's data, then issues the miss for the new block. A readable copy that is displaced is dropped without any message. Store data is merged into the line when the reply arrives, so a write miss leaves the line owned and holding the stored word.

Top module: `coh_cache_ctrl`

## Requirements
- R1: After a synchronous reset every line is not present, and `cpu_stall`, `cpu_resp_valid` and `msg_out_valid` are all low.
- R2: A load whose tag matches a readable (1) or owned (2) line is accepted when the controller is idle and no directory command is present. One cycle later `cpu_resp_valid` pulses with the stored word. No message is sent and the stall stays low.
- R3: A store whose tag matches an owned line updates the word locally. A response pulses one cycle later with no message, and later loads return the new word.
- R4: A load that misses raises `cpu_stall` one cycle after acceptance and emits a read-miss message at the same time (kind 0, address equal to the request address). The controller then waits. One cycle after a directory reply (input kind 0), the stall drops, a response pulses with the reply data, and the line becomes readable under the new tag.
- R5: A store to a line that is not owned with the same tag emits a write-miss message (kind 1). This covers an upgrade from readable. After the reply the line is owned and holds the store data; the reply data is ignored, and the response carries the store data.
- R6: An invalidate command (input kind 1) whose address matches a readable line makes it not present, with no message.
- R7: A fetch command (input kind 2) matching an owned line emits a write-back (kind 2, with the block address and word) two cycles later, and leaves the line readable.
- R8: A fetch-and-invalidate command (input kind 3) matching an owned line emits the same write-back and leaves the line not present.
- R9: A miss on a slot holding an owned line of another tag emits the old block's write-back two cycles after acceptance. The read-miss or write-miss for the new block follows in the next cycle.
- R10: A miss on a slot holding a readable line of another tag sends no write-back; the miss message follows at once as in R4 and R5.
- R11: A directory command that finds no line with its tag in the state it acts on changes nothing and produces no message. Commands other than a reply are also ignored while a miss is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req_valid | input | 1 | Processor request present; held until accepted |
| cpu_req_write | input | 1 | 1 = store, 0 = load |
| cpu_req_addr | input | ADDR_W | Word address: tag above, index in low bits |
| cpu_req_wdata | input | DATA_W | Store data |
| cpu_stall | output | 1 | Processor must wait |
| cpu_resp_valid | output | 1 | One-cycle completion pulse |
| cpu_resp_rdata | output | DATA_W | Load data (store data for stores) |
| dir_in_valid | input | 1 | Directory message present |
| dir_in_kind | input | 2 | 0 reply, 1 invalidate, 2 fetch, 3 fetch-and-invalidate |
| dir_in_addr | input | ADDR_W | Block address of a command |
| dir_in_data | input | DATA_W | Reply data |
| msg_out_valid | output | 1 | Outgoing message pulse |
| msg_out_kind | output | 2 | 0 read miss, 1 write miss, 2 write-back |
| msg_out_addr | output | ADDR_W | Block address of the message |
| msg_out_data | output | DATA_W | Write-back data |

## Verification
The bound checker watches the handshake shape on every cycle. It checks the quiet state after reset, that a response never coincides with a stall, and that a miss message always comes with a stall and is followed by silence. It also checks that an eviction write-back issued while stalled is followed at once by a miss message, and that message kinds stay legal. Whether the right line changed to the right state, whether the right word is written back or returned, and whether ignored commands left lines untouched can only be shown by the bench. The bench does this with a line-by-line model, through directed sequences per index and a long pseudo-random mix of loads, stores and commands over conflicting tags.

// File: rtl/coh_pkg.sv
package coh_pkg;
  typedef enum logic [1:0] {
    LN_ABSENT = 2'd0,
    LN_READ   = 2'd1,
    LN_OWNED  = 2'd2
  } line_st_e;

  typedef enum logic [1:0] {
    OUT_RDMISS = 2'd0,
    OUT_WRMISS = 2'd1,
    OUT_WBACK  = 2'd2
  } out_kind_e;

  typedef enum logic [1:0] {
    IN_REPLY    = 2'd0,
    IN_INVAL    = 2'd1,
    IN_FETCH    = 2'd2,
    IN_FETCHINV = 2'd3
  } in_kind_e;

  typedef enum logic [1:0] {
    CT_IDLE  = 2'd0,
    CT_WBACK = 2'd1,
    CT_REQ   = 2'd2,
    CT_WAIT  = 2'd3
  } ctl_e;
endpackage

// File: rtl/coh_line_table.sv
module coh_line_table
  import coh_pkg::*;
#(
  parameter int LINES = 64,
  parameter int IDX_W = 6,
  parameter int TAG_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] a_idx,
  output line_st_e         a_state,
  output logic [TAG_W-1:0] a_tag,
  input  logic [IDX_W-1:0] b_idx,
  output line_st_e         b_state,
  output logic [TAG_W-1:0] b_tag,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  line_st_e         wr_state,
  input  logic [TAG_W-1:0] wr_tag
);
  line_st_e         st_q  [LINES];
  logic [TAG_W-1:0] tag_q [LINES];

  always_ff @(posedge clk) begin
    for (int i = 0; i < LINES; i++) begin
      if (rst) begin
        st_q[i] <= LN_ABSENT;
      end else if (wr_en && wr_idx == IDX_W'(i)) begin
        st_q[i]  <= wr_state;
        tag_q[i] <= wr_tag;
      end
    end
  end

  assign a_state = st_q[a_idx];
  assign a_tag   = tag_q[a_idx];
  assign b_state = st_q[b_idx];
  assign b_tag   = tag_q[b_idx];
endmodule

// File: rtl/coh_data_ram.sv
module coh_data_ram #(
  parameter int DEPTH = 64,
  parameter int AW    = 6,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end
endmodule

// File: rtl/coh_cache_ctrl.sv
module coh_cache_ctrl
  import coh_pkg::*;
#(
  parameter int LINES  = 64,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req_valid,
  input  logic              cpu_req_write,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  input  logic [DATA_W-1:0] cpu_req_wdata,
  output logic              cpu_stall,
  output logic              cpu_resp_valid,
  output logic [DATA_W-1:0] cpu_resp_rdata,
  input  logic              dir_in_valid,
  input  logic [1:0]        dir_in_kind,
  input  logic [ADDR_W-1:0] dir_in_addr,
  input  logic [DATA_W-1:0] dir_in_data,
  output logic              msg_out_valid,
  output logic [1:0]        msg_out_kind,
  output logic [ADDR_W-1:0] msg_out_addr,
  output logic [DATA_W-1:0] msg_out_data
);
  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - IDX_W;

  // request and command fields
  logic [IDX_W-1:0] c_idx, d_idx;
  logic [TAG_W-1:0] c_tag, d_tag;
  in_kind_e         d_kind;
  assign c_idx  = cpu_req_addr[IDX_W-1:0];
  assign c_tag  = cpu_req_addr[ADDR_W-1:IDX_W];
  assign d_idx  = dir_in_addr[IDX_W-1:0];
  assign d_tag  = dir_in_addr[ADDR_W-1:IDX_W];
  assign d_kind = in_kind_e'(dir_in_kind);

  // registers
  ctl_e              ctl_q, ctl_d;
  logic [IDX_W-1:0]  pend_idx_q;
  logic [TAG_W-1:0]  pend_tag_q;
  logic              pend_wr_q;
  logic [DATA_W-1:0] pend_wdata_q;
  logic [ADDR_W-1:0] wb_addr_q;
  logic              wb_then_req_q;
  logic              stall_q;
  logic              resp_v_q, resp_mem_q;
  logic [DATA_W-1:0] resp_data_q;
  logic              mo_v_q;
  out_kind_e         mo_kind_q;
  logic [ADDR_W-1:0] mo_addr_q;
  logic [DATA_W-1:0] mo_data_q;

  // line table
  line_st_e         a_state, b_state, t_wstate;
  logic [TAG_W-1:0] a_tag, b_tag, t_wtag;
  logic [IDX_W-1:0] t_widx;
  logic             t_we;

  coh_line_table #(.LINES(LINES), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_lines (
    .clk(clk), .rst(rst),
    .a_idx(c_idx), .a_state(a_state), .a_tag(a_tag),
    .b_idx(d_idx), .b_state(b_state), .b_tag(b_tag),
    .wr_en(t_we), .wr_idx(t_widx), .wr_state(t_wstate), .wr_tag(t_wtag)
  );

  // data array
  logic              r_we;
  logic [IDX_W-1:0]  r_addr;
  logic [DATA_W-1:0] r_wdata, r_q;

  coh_data_ram #(.DEPTH(LINES), .AW(IDX_W), .DW(DATA_W)) u_data (
    .clk(clk), .we(r_we), .addr(r_addr), .wdata(r_wdata), .rdata(r_q)
  );

  // decode
  logic idle, waiting, dir_cmd, reply_in, cpu_go;
  logic c_match, c_hit, c_evict, d_match;
  logic do_inval, do_fetch, do_finv;

  assign idle     = (ctl_q == CT_IDLE);
  assign waiting  = (ctl_q == CT_WAIT);
  assign dir_cmd  = idle && dir_in_valid && (d_kind != IN_REPLY);
  assign reply_in = waiting && dir_in_valid && (d_kind == IN_REPLY);
  assign cpu_go   = idle && cpu_req_valid && !dir_cmd;

  assign c_match  = (a_state != LN_ABSENT) && (a_tag == c_tag);
  assign c_hit    = c_match && (!cpu_req_write || a_state == LN_OWNED);
  assign c_evict  = (a_state == LN_OWNED) && (a_tag != c_tag);
  assign d_match  = (b_state != LN_ABSENT) && (b_tag == d_tag);
  assign do_inval = dir_cmd && d_match && d_kind == IN_INVAL    && b_state == LN_READ;
  assign do_fetch = dir_cmd && d_match && d_kind == IN_FETCH    && b_state == LN_OWNED;
  assign do_finv  = dir_cmd && d_match && d_kind == IN_FETCHINV && b_state == LN_OWNED;

  // data array port
  always_comb begin
    r_we    = 1'b0;
    r_addr  = c_idx;
    r_wdata = cpu_req_wdata;
    if (waiting) begin
      r_addr  = pend_idx_q;
      r_we    = reply_in;
      r_wdata = pend_wr_q ? pend_wdata_q : dir_in_data;
    end else if (dir_cmd) begin
      r_addr = d_idx;
    end else if (cpu_go && c_hit && cpu_req_write) begin
      r_we = 1'b1;
    end
  end

  // line table write port
  always_comb begin
    t_we     = 1'b0;
    t_widx   = d_idx;
    t_wtag   = b_tag;
    t_wstate = LN_ABSENT;
    if (reply_in) begin
      t_we     = 1'b1;
      t_widx   = pend_idx_q;
      t_wtag   = pend_tag_q;
      t_wstate = pend_wr_q ? LN_OWNED : LN_READ;
    end else if (do_inval || do_finv) begin
      t_we = 1'b1;
    end else if (do_fetch) begin
      t_we     = 1'b1;
      t_wstate = LN_READ;
    end
  end

  // next control state
  always_comb begin
    ctl_d = ctl_q;
    unique case (ctl_q)
      CT_IDLE: begin
        if (do_fetch || do_finv)        ctl_d = CT_WBACK;
        else if (cpu_go && !c_hit)      ctl_d = c_evict ? CT_WBACK : CT_WAIT;
      end
      CT_WBACK: ctl_d = wb_then_req_q ? CT_REQ : CT_IDLE;
      CT_REQ:   ctl_d = CT_WAIT;
      CT_WAIT:  if (reply_in) ctl_d = CT_IDLE;
      default:  ctl_d = CT_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q         <= CT_IDLE;
      stall_q       <= 1'b0;
      resp_v_q      <= 1'b0;
      resp_mem_q    <= 1'b0;
      mo_v_q        <= 1'b0;
      mo_kind_q     <= OUT_RDMISS;
      wb_then_req_q <= 1'b0;
      pend_wr_q     <= 1'b0;
    end else begin
      ctl_q    <= ctl_d;
      stall_q  <= (ctl_d != CT_IDLE);
      resp_v_q <= 1'b0;
      mo_v_q   <= 1'b0;
      unique case (ctl_q)
        CT_IDLE: begin
          if (do_fetch || do_finv) begin
            wb_addr_q     <= {b_tag, d_idx};
            wb_then_req_q <= 1'b0;
          end else if (cpu_go) begin
            if (c_hit) begin
              resp_v_q    <= 1'b1;
              resp_mem_q  <= !cpu_req_write;
              resp_data_q <= cpu_req_wdata;
            end else begin
              pend_idx_q   <= c_idx;
              pend_tag_q   <= c_tag;
              pend_wr_q    <= cpu_req_write;
              pend_wdata_q <= cpu_req_wdata;
              if (c_evict) begin
                wb_addr_q     <= {a_tag, c_idx};
                wb_then_req_q <= 1'b1;
              end else begin
                mo_v_q    <= 1'b1;
                mo_kind_q <= cpu_req_write ? OUT_WRMISS : OUT_RDMISS;
                mo_addr_q <= cpu_req_addr;
              end
            end
          end
        end
        CT_WBACK: begin
          mo_v_q    <= 1'b1;
          mo_kind_q <= OUT_WBACK;
          mo_addr_q <= wb_addr_q;
          mo_data_q <= r_q;
        end
        CT_REQ: begin
          mo_v_q    <= 1'b1;
          mo_kind_q <= pend_wr_q ? OUT_WRMISS : OUT_RDMISS;
          mo_addr_q <= {pend_tag_q, pend_idx_q};
        end
        CT_WAIT: begin
          if (reply_in) begin
            resp_v_q    <= 1'b1;
            resp_mem_q  <= 1'b0;
            resp_data_q <= pend_wr_q ? pend_wdata_q : dir_in_data;
          end
        end
        default: ;
      endcase
    end
  end

  assign cpu_stall      = stall_q;
  assign cpu_resp_valid = resp_v_q;
  assign cpu_resp_rdata = resp_mem_q ? r_q : resp_data_q;
  assign msg_out_valid  = mo_v_q;
  assign msg_out_kind   = mo_kind_q;
  assign msg_out_addr   = mo_addr_q;
  assign msg_out_data   = mo_data_q;
endmodule

// File: rtl/coh_cache_ctrl_chk.sv
module coh_cache_ctrl_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              cpu_stall,
  input logic              cpu_resp_valid,
  input logic              msg_out_valid,
  input logic [1:0]        msg_out_kind,
  input logic [ADDR_W-1:0] msg_out_addr,
  input logic [DATA_W-1:0] msg_out_data
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!cpu_stall && !cpu_resp_valid && !msg_out_valid));

  // R2
  resp_unstalled_chk: assert property (@(posedge clk) disable iff (rst)
    cpu_resp_valid |-> !cpu_stall);

  // R4
  miss_stalls_chk: assert property (@(posedge clk) disable iff (rst)
    (msg_out_valid && msg_out_kind != 2'd2) |-> cpu_stall);

  // R5
  miss_then_silence_chk: assert property (@(posedge clk) disable iff (rst)
    (msg_out_valid && msg_out_kind != 2'd2) |=> (!msg_out_valid && cpu_stall));

  // R9
  evict_then_miss_chk: assert property (@(posedge clk) disable iff (rst)
    (msg_out_valid && msg_out_kind == 2'd2 && cpu_stall) |=>
      (msg_out_valid && msg_out_kind != 2'd2));

  // R7
  legal_kind_chk: assert property (@(posedge clk) disable iff (rst)
    msg_out_valid |-> (msg_out_kind != 2'd3));
endmodule

bind coh_cache_ctrl coh_cache_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .cpu_stall(cpu_stall), .cpu_resp_valid(cpu_resp_valid),
  .msg_out_valid(msg_out_valid), .msg_out_kind(msg_out_kind),
  .msg_out_addr(msg_out_addr), .msg_out_data(msg_out_data)
);

// File: tb/test_coh_cache_ctrl.sv
module test_coh_cache_ctrl;
  localparam int LINES = 4;
  localparam int AW    = 6;
  localparam int DW    = 8;
  localparam int IW    = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cpu_req_valid = 1'b0, cpu_req_write = 1'b0;
  logic [AW-1:0] cpu_req_addr = '0;
  logic [DW-1:0] cpu_req_wdata = '0;
  logic cpu_stall, cpu_resp_valid;
  logic [DW-1:0] cpu_resp_rdata;
  logic dir_in_valid = 1'b0;
  logic [1:0] dir_in_kind = 2'd0;
  logic [AW-1:0] dir_in_addr = '0;
  logic [DW-1:0] dir_in_data = '0;
  logic msg_out_valid;
  logic [1:0] msg_out_kind;
  logic [AW-1:0] msg_out_addr;
  logic [DW-1:0] msg_out_data;

  always #5 clk = ~clk;

  coh_cache_ctrl #(.LINES(LINES), .ADDR_W(AW), .DATA_W(DW)) i_coh_cache_ctrl (.*);

  int n_chk = 0, n_bad = 0;
  int ms [LINES];
  int mt [LINES];
  int md [LINES];

  task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s act=%0h exp=%0h", rq, what, act, exp);
    end
  endtask

  task automatic quiet(input string rq, input bit stall_exp);
    chk(!msg_out_valid, rq, "no msg", int'(msg_out_valid), 0);
    chk(cpu_stall == stall_exp, rq, "stall", int'(cpu_stall), int'(stall_exp));
  endtask

  task automatic cpu_access(input bit wr, input logic [AW-1:0] addr,
                            input logic [DW-1:0] wd, input logic [DW-1:0] rep);
    int idx, tg;
    bit hit, ev;
    string rq;
    idx = int'(addr[IW-1:0]);
    tg  = int'(addr[AW-1:IW]);
    hit = ms[idx] != 0 && mt[idx] == tg && (!wr || ms[idx] == 2);
    ev  = ms[idx] == 2 && mt[idx] != tg;
    if (hit)                                 rq = wr ? "R3" : "R2";
    else if (ev)                             rq = "R9";
    else if (ms[idx] == 1 && mt[idx] != tg)  rq = "R10";
    else                                     rq = wr ? "R5" : "R4";
    cpu_req_valid = 1'b1; cpu_req_write = wr; cpu_req_addr = addr; cpu_req_wdata = wd;
    @(negedge clk);
    cpu_req_valid = 1'b0;
    if (hit) begin
      chk(cpu_resp_valid, rq, "hit resp", int'(cpu_resp_valid), 1);
      quiet(rq, 1'b0);
      if (!wr) chk(cpu_resp_rdata == DW'(md[idx]), rq, "hit data", int'(cpu_resp_rdata), md[idx]);
      else md[idx] = int'(wd);
    end else begin
      chk(cpu_stall, rq, "miss stall", int'(cpu_stall), 1);
      if (ev) begin
        chk(!msg_out_valid, rq, "gap before wb", int'(msg_out_valid), 0);
        @(negedge clk);
        chk(msg_out_valid && msg_out_kind == 2'd2, rq, "wb kind", int'(msg_out_kind), 2);
        chk(msg_out_addr == AW'((mt[idx] << IW) | idx), rq, "wb addr", int'(msg_out_addr), (mt[idx] << IW) | idx);
        chk(msg_out_data == DW'(md[idx]), rq, "wb data", int'(msg_out_data), md[idx]);
        @(negedge clk);
      end
      chk(msg_out_valid && msg_out_kind == (wr ? 2'd1 : 2'd0), rq, "miss kind",
          int'(msg_out_kind), wr ? 1 : 0);
      chk(msg_out_addr == addr, rq, "miss addr", int'(msg_out_addr), int'(addr));
      @(negedge clk);
      quiet(rq, 1'b1);
      dir_in_valid = 1'b1; dir_in_kind = 2'd0; dir_in_data = rep; dir_in_addr = addr;
      @(negedge clk);
      dir_in_valid = 1'b0;
      chk(!cpu_stall && cpu_resp_valid, rq, "reply release", int'(cpu_stall), 0);
      chk(cpu_resp_rdata == (wr ? wd : rep), rq, "reply data", int'(cpu_resp_rdata),
          int'(wr ? wd : rep));
      ms[idx] = wr ? 2 : 1;
      mt[idx] = tg;
      md[idx] = int'(wr ? wd : rep);
    end
  endtask

  task automatic dir_cmd(input logic [1:0] kind, input logic [AW-1:0] addr);
    int idx, tg;
    bit m, wb;
    string rq;
    idx = int'(addr[IW-1:0]);
    tg  = int'(addr[AW-1:IW]);
    m   = ms[idx] != 0 && mt[idx] == tg;
    wb  = 1'b0;
    rq  = "R11";
    if (kind == 2'd1 && m && ms[idx] == 1) begin rq = "R6"; ms[idx] = 0; end
    else if (kind == 2'd2 && m && ms[idx] == 2) begin rq = "R7"; wb = 1'b1; ms[idx] = 1; end
    else if (kind == 2'd3 && m && ms[idx] == 2) begin rq = "R8"; wb = 1'b1; ms[idx] = 0; end
    dir_in_valid = 1'b1; dir_in_kind = kind; dir_in_addr = addr;
    @(negedge clk);
    dir_in_valid = 1'b0;
    quiet(rq, wb);
    @(negedge clk);
    if (wb) begin
      chk(msg_out_valid && msg_out_kind == 2'd2, rq, "cmd wb kind", int'(msg_out_kind), 2);
      chk(msg_out_addr == addr, rq, "cmd wb addr", int'(msg_out_addr), int'(addr));
      chk(msg_out_data == DW'(md[idx]), rq, "cmd wb data", int'(msg_out_data), md[idx]);
    end else begin
      quiet(rq, 1'b0);
    end
  endtask

  function automatic logic [AW-1:0] mk(input int tg, input int idx);
    return AW'((tg << IW) | idx);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog (all requirements) act=running exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] seed;
    for (int i = 0; i < LINES; i++) begin ms[i] = 0; mt[i] = 0; md[i] = 0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: quiet after reset
    chk(!cpu_stall && !cpu_resp_valid && !msg_out_valid, "R1", "reset outputs",
        int'({cpu_stall, cpu_resp_valid, msg_out_valid}), 0);

    for (int idx = 0; idx < LINES; idx++) begin
      cpu_access(1'b0, mk(1, idx), 8'h00, DW'(8'h10 + idx));     // R4 (R1: line starts absent)
      cpu_access(1'b0, mk(1, idx), 8'h00, 8'h00);                // R2
      cpu_access(1'b1, mk(1, idx), DW'(8'h40 + idx), 8'hEE);     // R5 upgrade
      cpu_access(1'b1, mk(1, idx), DW'(8'h50 + idx), 8'h00);     // R3
      cpu_access(1'b0, mk(1, idx), 8'h00, 8'h00);                // R2
      dir_cmd(2'd2, mk(1, idx));                                 // R7
      cpu_access(1'b0, mk(1, idx), 8'h00, 8'h00);                // R2
      dir_cmd(2'd2, mk(1, idx));                                 // R11 fetch on readable
      cpu_access(1'b1, mk(1, idx), DW'(8'h60 + idx), 8'hEE);     // R5
      dir_cmd(2'd3, mk(1, idx));                                 // R8
      dir_cmd(2'd1, mk(1, idx));                                 // R11 on absent
      cpu_access(1'b0, mk(1, idx), 8'h00, DW'(8'h70 + idx));     // R4
      dir_cmd(2'd1, mk(2, idx));                                 // R11 other tag
      dir_cmd(2'd1, mk(1, idx));                                 // R6
      cpu_access(1'b1, mk(2, idx), DW'(8'h80 + idx), 8'hEE);     // R5
      cpu_access(1'b0, mk(1, idx), 8'h00, DW'(8'h90 + idx));     // R9
      cpu_access(1'b1, mk(3, idx), DW'(8'hA0 + idx), 8'hEE);     // R10
      cpu_access(1'b1, mk(2, idx), DW'(8'hB0 + idx), 8'hEE);     // R9
    end

    seed = 32'h1234_5678;
    for (int n = 0; n < 1500; n++) begin
      int op, tg, idx;
      seed = seed * 32'd1103515245 + 32'd12345;
      op  = int'(seed[26:24]);
      tg  = int'(seed[21:20]) % 3;
      idx = int'(seed[17:16]);
      case (op)
        0, 1, 2: cpu_access(1'b0, mk(tg, idx), 8'h00, seed[7:0]);
        3, 4:    cpu_access(1'b1, mk(tg, idx), seed[15:8], seed[7:0]);
        5:       dir_cmd(2'd1, mk(tg, idx));
        6:       dir_cmd(2'd2, mk(tg, idx));
        default: dir_cmd(2'd3, mk(tg, idx));
      endcase
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule